// File: doc/BRIEF.md
# Segment-Based Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. The selector chooses one of two descriptor tables, global or local, and an entry within it. The block reads the 8-byte descriptor through a simple request/acknowledge memory port as two 32-bit words. It then widens the 20-bit limit according to the descriptor's granularity flag and checks the offset against the result. A translation within the limit ends with a one-cycle valid pulse that carries base plus offset. A translation beyond the limit ends with a one-cycle fault pulse instead.

The surrounding logic supplies the two table base addresses. It presents one request at a time while `busy_o` is low. It serves the memory port with any number of wait states per word.

Top module: `segx_top`

## Requirements
- R1: The selector's bits 15:3 are the descriptor index. Bit 2 selects the table: 0 means the global table and 1 means the local table. Bits 1:0 have no effect on the translation.
- R2: The descriptor's low word is read at table base + index*8, and its high word at that address + 4. The table base is taken from `gdt_base_i` or `ldt_base_i` in the cycle the request is accepted. Later changes to those inputs do not affect a translation already in progress.
- R3: The descriptor's low word is the 32-bit segment base. In the high word, bits 19:0 hold the limit and bit 23 holds the granularity flag. All other high-word bits are ignored.
- R4: With granularity 0, the effective limit is the 20-bit limit counted in bytes. With granularity 1, the effective limit is the limit shifted left by 12 with the low 12 bits filled with ones.
- R5: If the offset is less than or equal to the effective limit, `lin_valid_o` pulses for one cycle with `lin_addr_o` = base + offset, modulo 2^32.
- R6: If the offset is greater than the effective limit, `fault_o` pulses for one cycle. In that cycle `lin_valid_o` is low and `lin_addr_o` is zero.
- R7: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i` is seen. `mem_rdata_i` is taken in the acknowledge cycle. Any number of wait states is tolerated.
- R8: `busy_o` is high from the cycle after acceptance through the result cycle, and low in the cycle after the result. A request presented while `busy_o` is high is ignored. Each accepted request gives exactly one result pulse.
- R9: During and right after reset, `busy_o`, `mem_req_o`, `lin_valid_o` and `fault_o` are low.
- R10: With zero-wait memory, the result is visible after the third rising edge, counting the accepting edge. Each wait state adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base_i | input | 32 | Global descriptor table base address |
| ldt_base_i | input | 32 | Local descriptor table base address |
| req_valid_i | input | 1 | Translation request, accepted when `busy_o` is low |
| req_sel_i | input | 16 | Segment selector |
| req_off_i | input | 32 | Offset within the segment |
| busy_o | output | 1 | Translation in progress |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Byte address of the descriptor word |
| mem_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| lin_valid_o | output | 1 | Linear address valid pulse |
| lin_addr_o | output | 32 | Linear address |
| fault_o | output | 1 | Limit violation pulse |

## Verification
Two events can coincide: a new request, and the result pulse of the previous translation. The bench keeps `req_valid_i` asserted, with a different selector, from acceptance through the result cycle. It also changes the global table base in mid-walk. It then judges three things: that only the first selector's two descriptor addresses appear on the memory port, that the single result matches the first request, and that `busy_o` and `mem_req_o` are low in the cycle after the result.

// File: rtl/segx_pkg.sv
package segx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD_LO = 2'd1,
      ST_RD_HI = 2'd2,
      ST_DONE  = 2'd3
   } segx_state_e;
endpackage

// File: rtl/segx_sel_decode.sv
module segx_sel_decode #(
   parameter int SEL_W      = 16,
   parameter int ADDR_W     = 32,
   parameter int IDX_LSB    = 3,
   parameter int TI_BIT     = 2,
   parameter int DESC_SHIFT = 3
) (
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [ADDR_W-1:0] gdt_base_i,
   input  logic [ADDR_W-1:0] ldt_base_i,
   output logic [ADDR_W-1:0] desc_addr_o
);
   localparam int IDX_W = SEL_W - IDX_LSB;

   generate
      if (IDX_LSB <= TI_BIT) begin : g_bad_layout
         $error("segx_sel_decode: index must sit above the table bit");
      end
      if (IDX_W + DESC_SHIFT > ADDR_W) begin : g_bad_width
         $error("segx_sel_decode: scaled index exceeds address width");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] tbl_base;
   logic              unused_rpl;

   assign idx        = sel_i[SEL_W-1:IDX_LSB];
   // R1: table bit picks local (1) or global (0)
   assign tbl_base   = sel_i[TI_BIT] ? ldt_base_i : gdt_base_i;
   assign unused_rpl = ^sel_i[TI_BIT-1:0];
   // R2: entry address = base + index * descriptor size
   assign desc_addr_o = tbl_base + (ADDR_W'(idx) << DESC_SHIFT);
endmodule

// File: rtl/segx_desc_fetch.sv
module segx_desc_fetch
   import segx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [DATA_W-1:0] word_lo_o,
   output logic [DATA_W-1:0] word_hi_o
);
   localparam int WORD_BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("segx_desc_fetch: data width must be whole bytes");
      end
   endgenerate

   segx_state_e       st;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         addr_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start_i) begin
               addr_q <= addr_i;
               st     <= ST_RD_LO;
            end
            ST_RD_LO: if (mem_ack_i) begin
               lo_q   <= mem_rdata_i;
               addr_q <= addr_q + ADDR_W'(WORD_BYTES);
               st     <= ST_RD_HI;
            end
            ST_RD_HI: if (mem_ack_i) begin
               hi_q <= mem_rdata_i;
               st   <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (st != ST_IDLE);
   assign done_o     = (st == ST_DONE);
   assign mem_req_o  = (st == ST_RD_LO) || (st == ST_RD_HI);
   assign mem_addr_o = addr_q;
   assign word_lo_o  = lo_q;
   assign word_hi_o  = hi_q;

   // R7: a pending request holds its address until acknowledged
   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
   // R2: second word follows the first one word higher
   a_r2_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_LO && mem_ack_i) |=>
         (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)));
   // R8: no memory traffic while idle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);
endmodule

// File: rtl/segx_limit_check.sv
module segx_limit_check #(
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int GRAN_BIT   = 23
) (
   input  logic [DATA_W-1:0] word_lo_i,
   input  logic [DATA_W-1:0] word_hi_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic              in_range_o,
   output logic [OFF_W-1:0]  sum_o
);
   generate
      if (LIMIT_W + GRAN_SHIFT > OFF_W) begin : g_bad_scale
         $error("segx_limit_check: scaled limit wider than offset");
      end
      if (GRAN_BIT <= LIMIT_W || GRAN_BIT >= DATA_W) begin : g_bad_gbit
         $error("segx_limit_check: granularity bit placement invalid");
      end
   endgenerate

   logic [LIMIT_W-1:0] lim;
   logic               gran;
   logic [OFF_W-1:0]   eff_lim;
   logic               unused_hi;

   assign lim       = word_hi_i[LIMIT_W-1:0];
   assign gran      = word_hi_i[GRAN_BIT];
   assign unused_hi = ^{word_hi_i[DATA_W-1:GRAN_BIT+1], word_hi_i[GRAN_BIT-1:LIMIT_W]};

   // R4: coarse granularity fills the low bits with ones
   generate
      if (GRAN_SHIFT > 0) begin : g_scaled
         assign eff_lim = gran ? OFF_W'({lim, {GRAN_SHIFT{1'b1}}}) : OFF_W'(lim);
      end else begin : g_flat
         assign eff_lim = OFF_W'(lim);
      end
   endgenerate

   assign in_range_o = (off_i <= eff_lim);
   assign sum_o      = OFF_W'(word_lo_i) + off_i;
endmodule

// File: rtl/segx_top.sv
module segx_top #(
   parameter int SEL_W      = 16,
   parameter int OFF_W      = 32,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int GRAN_BIT   = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] gdt_base_i,
   input  logic [ADDR_W-1:0] ldt_base_i,
   input  logic              req_valid_i,
   input  logic [SEL_W-1:0]  req_sel_i,
   input  logic [OFF_W-1:0]  req_off_i,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              lin_valid_o,
   output logic [OFF_W-1:0]  lin_addr_o,
   output logic              fault_o
);
   generate
      if (OFF_W != ADDR_W || DATA_W != ADDR_W) begin : g_bad_widths
         $error("segx_top: offset, address and data widths must match");
      end
   endgenerate

   logic              accept, done;
   logic [ADDR_W-1:0] desc_addr;
   logic [OFF_W-1:0]  off_q, sum;
   logic [DATA_W-1:0] w_lo, w_hi;
   logic              in_range;

   assign accept = req_valid_i && !busy_o;

   segx_sel_decode #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
      .sel_i(req_sel_i), .gdt_base_i(gdt_base_i), .ldt_base_i(ldt_base_i),
      .desc_addr_o(desc_addr)
   );

   segx_desc_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .addr_i(desc_addr),
      .busy_o(busy_o), .done_o(done), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .word_lo_o(w_lo), .word_hi_o(w_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_q <= '0;
      else if (accept) off_q <= req_off_i;
   end

   segx_limit_check #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LIMIT_W(LIMIT_W),
                      .GRAN_SHIFT(GRAN_SHIFT), .GRAN_BIT(GRAN_BIT)) u_lim (
      .word_lo_i(w_lo), .word_hi_i(w_hi), .off_i(off_q),
      .in_range_o(in_range), .sum_o(sum)
   );

   assign lin_valid_o = done && in_range;
   assign fault_o     = done && !in_range;
   assign lin_addr_o  = lin_valid_o ? sum : '0;

   // R6: a fault never carries an address
   a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!lin_valid_o && lin_addr_o == '0));
   // R8: results only appear while busy
   a_r8_result_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid_o || fault_o) |-> busy_o);
   // R8: one pulse per translation, then idle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid_o || fault_o) |=> (!busy_o && !lin_valid_o && !fault_o));
   // R8: the offset register is frozen during a walk
   a_r8_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !lin_valid_o && !fault_o) |=> $stable(off_q));
endmodule

// File: tb/segx_top_bench.sv
`timescale 1ns/1ps
module segx_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] gdt_base_i = 32'h40, ldt_base_i = 32'h200;
   logic        req_valid_i = 1'b0;
   logic [15:0] req_sel_i = '0;
   logic [31:0] req_off_i = '0;
   logic        busy_o, mem_req_o, lin_valid_o, fault_o;
   logic [31:0] mem_addr_o, lin_addr_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   always #2.5 clk = ~clk;

   segx_top u_segx_top (.*);

   int n_chk = 0, n_bad = 0;
   logic [31:0] mem [0:255];
   logic [31:0] d_base [0:1][0:7];
   logic [19:0] d_lim  [0:1][0:7];
   logic        d_g    [0:1][0:7];
   int mem_wait = 0, wcnt = 0, nseen = 0;
   logic [31:0] seen [0:1];

   always @(negedge clk) begin
      if (mem_req_o && wcnt >= mem_wait) begin
         mem_ack_i = 1'b1;
         mem_rdata_i = mem[mem_addr_o[9:2]];
         if (nseen < 2) seen[nseen] = mem_addr_o;
         nseen++;
         wcnt = 0;
      end else if (mem_req_o) begin
         mem_ack_i = 1'b0; wcnt++;
      end else begin
         mem_ack_i = 1'b0; wcnt = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R3: noise in ignored high-word bits
   task automatic put_desc(input int t, input int idx, input logic [31:0] b, input logic [19:0] l, input bit g);
      int a;
      a = ((t ? 32'h200 : 32'h40) + idx * 8) >> 2;
      d_base[t][idx] = b; d_lim[t][idx] = l; d_g[t][idx] = g;
      mem[a]     = b;
      mem[a + 1] = {8'hA5, g, 3'b101, l};
   endtask

   task automatic run(input logic [15:0] sel, input logic [31:0] off,
                      output logic v, output logic f, output logic [31:0] la, output int cyc);
      @(negedge clk);
      req_valid_i = 1'b1; req_sel_i = sel; req_off_i = off; nseen = 0;
      @(posedge clk); cyc = 1;
      @(negedge clk); req_valid_i = 1'b0;
      while (!(lin_valid_o || fault_o) && cyc < 60) begin
         @(posedge clk); cyc++; @(negedge clk);
      end
      v = lin_valid_o; f = fault_o; la = lin_addr_o;
   endtask

   function automatic void model(input logic [15:0] sel, input logic [31:0] off,
                                 output logic flt, output logic [31:0] la, output logic [31:0] da);
      int t, i;
      logic [31:0] eff;
      t = sel[2]; i = sel[15:3];
      da = (t ? 32'h200 : 32'h40) + i * 8;
      eff = d_g[t][i] ? {d_lim[t][i], 12'hFFF} : {12'h0, d_lim[t][i]};
      flt = off > eff;
      la = flt ? 32'h0 : d_base[t][i] + off;
   endfunction

   // {selector, offset}
   localparam logic [47:0] VEC [0:13] = '{
      {16'h0000, 32'h0000_0FFF}, {16'h0000, 32'h0000_1000}, {16'h0003, 32'h0000_0000},
      {16'h0008, 32'h0000_3FFF}, {16'h0008, 32'h0000_4000}, {16'h0028, 32'hFFFF_FFFF},
      {16'h0004, 32'h0000_0010}, {16'h0007, 32'h0000_0011}, {16'h0014, 32'h0000_0FFF},
      {16'h0014, 32'h0000_1000}, {16'h003C, 32'h000F_FFFF}, {16'h003C, 32'h0010_0000},
      {16'h002C, 32'h0000_0000}, {16'h0004, 32'h0000_0000}
   };

   bit finished = 1'b0;
   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic v, f, ef;
      logic [31:0] la, ela, eda;
      int cyc;
      for (int k = 0; k < 256; k++) mem[k] = 32'h0;
      for (int t = 0; t < 2; t++)
         for (int i = 0; i < 8; i++) put_desc(t, i, 32'h0, 20'h0, 1'b0);
      put_desc(0, 0, 32'h1000_0000, 20'h00FFF, 1'b0);
      put_desc(0, 1, 32'h0040_0000, 20'h00003, 1'b1);
      put_desc(0, 5, 32'hFFFF_F000, 20'hFFFFF, 1'b1);
      put_desc(1, 0, 32'h2000_0000, 20'h00010, 1'b0);
      put_desc(1, 2, 32'h0000_8000, 20'h00000, 1'b1);
      put_desc(1, 5, 32'hCAFE_0000, 20'h00100, 1'b0);
      put_desc(1, 7, 32'h1234_5678, 20'hFFFFF, 1'b0);

      // R9: reset state
      repeat (2) @(negedge clk);
      check(!busy_o && !mem_req_o && !lin_valid_o && !fault_o, "R9 in reset",
            {busy_o, mem_req_o, lin_valid_o, fault_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !mem_req_o && !lin_valid_o && !fault_o, "R9 after reset",
            {busy_o, mem_req_o, lin_valid_o, fault_o}, 0);

      // R1 R2 R3 R4 R5 R6 R10: vector table
      for (int n = 0; n < 14; n++) begin
         run(VEC[n][47:32], VEC[n][31:0], v, f, la, cyc);
         model(VEC[n][47:32], VEC[n][31:0], ef, ela, eda);
         check(f == ef && v == !ef, $sformatf("R6 R4 vec%0d fault", n), {v, f}, {!ef, ef});
         check(la == ela, $sformatf("R5 vec%0d linear", n), la, ela);
         check(seen[0] == eda, $sformatf("R2 R1 vec%0d lo addr", n), seen[0], eda);
         check(seen[1] == eda + 4, $sformatf("R2 vec%0d hi addr", n), seen[1], eda + 4);
         check(cyc == 3, $sformatf("R10 vec%0d latency", n), cyc, 3);
         @(negedge clk);
         check(!busy_o, $sformatf("R8 vec%0d idle after", n), busy_o, 0);
      end

      // R7 R10: wait states on memory
      mem_wait = 2;
      run(16'h0008, 32'h0000_0100, v, f, la, cyc);
      check(v && la == 32'h0040_0100, "R7 wait-state result", la, 32'h0040_0100);
      check(cyc == 7, "R10 wait-state latency", cyc, 7);
      mem_wait = 0;
      @(negedge clk);

      // R8 R2: request held through a walk, base changed mid-walk
      @(negedge clk);
      req_valid_i = 1'b1; req_sel_i = 16'h0000; req_off_i = 32'h10; nseen = 0;
      @(posedge clk);
      @(negedge clk);
      req_sel_i = 16'h0029; req_off_i = 32'h5; gdt_base_i = 32'h80;
      while (!(lin_valid_o || fault_o)) begin @(posedge clk); @(negedge clk); end
      check(lin_valid_o && lin_addr_o == 32'h1000_0010, "R8 first request wins", lin_addr_o, 32'h1000_0010);
      check(seen[0] == 32'h40 && seen[1] == 32'h44, "R2 base sampled at accept", seen[0], 32'h40);
      req_valid_i = 1'b0;
      @(negedge clk);
      check(!busy_o && !mem_req_o && !lin_valid_o, "R8 busy request ignored", {busy_o, mem_req_o}, 0);
      check(nseen == 2, "R8 two reads only", nseen, 2);
      gdt_base_i = 32'h40;

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule